// File: doc/BRIEF.md
# Three-Wire Serial Configuration Receiver

This block receives configuration from a write-only three-line serial bus (serial clock, serial data, active-low enable) and keeps two configuration words in field registers. The three bus lines are asynchronous to the system clock. They pass through multi-flop synchronizers, and every edge is detected in the system clock domain. While enable is low, each rising edge of the serial clock shifts one data bit, most significant bit first, into a 24-bit shift register. The shift register is cleared when enable falls.

When enable returns high, the last bit shifted in is the address. An address of 1 copies the 23 bits above it into the synthesizer word. An address of 0 copies the 11 bits above it into the tuning word. Leading bits beyond the register width fall off the top, and the number of clock pulses is never checked. A transfer with no clock edges writes nothing.

The controller has three states: `ST_IDLE`, `ST_SHIFT` and `ST_COMMIT`. The transitions are as follows:
- `ST_IDLE`→`ST_SHIFT` when enable is seen low; this clears the shift register.
- `ST_SHIFT`→`ST_COMMIT` when enable is seen high and at least one edge arrived, counting an edge in that same cycle.
- `ST_SHIFT`→`ST_IDLE` when enable is seen high and no edge arrived.
- `ST_COMMIT`→`ST_IDLE` always, after one cycle in which the addressed word is written.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, every field output is zero.
- R2: A transfer whose last bit is 1 loads the 23 bits before it into the synthesizer word. Bit 0 is the bit just before the address. The field positions within the word are: 22:21 `ref_code`, 20:16 `swallow_cnt`, 15:14 `main_code`, 13 `osc_tx`, 12 unused, 11 `test_qual`, 10 `filt_en`, 9 `comp_en`, 8:6 `dev_scale`, 5:3 `pretune` and 2:0 `cp_step`.
- R3: A transfer whose last bit is 0 loads the 11 bits before it into the tuning word, at positions 10:6 `demod_tune`, 5:3 `comp_scale` and 2:0 `test_sel`. The synthesizer word is left unchanged.
- R4: A transfer with address 1 leaves the tuning word unchanged.
- R5: When more than 24 bits are shifted, only the last 24 bits count and the earlier bits are discarded.
- R6: When fewer than 24 bits are shifted, the positions not reached read as zero, because the shift register is cleared when enable falls.
- R7: A transfer with no serial clock rising edge while enable is low leaves both words unchanged.
- R8: Serial clock edges while enable is high have no effect on the words or on the next transfer.
- R9: A serial clock rising edge that is seen in the same system cycle as the rise of enable is shifted in as the final (address) bit.
- R10: The outputs change only in the one-cycle commit that follows the rise of enable. They do not change while enable is still low.
- R11: `cp_step` is a two's-complement value from -4 (code 100) to +3 (code 011).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bus clock (asynchronous) |
| ser_dat | input | 1 | Serial bus data, MSB first |
| ser_en | input | 1 | Serial bus enable, active low |
| ref_code | output | 2 | Reference divider code |
| swallow_cnt | output | 5 | Swallow counter value |
| main_code | output | 2 | Main divider code |
| osc_tx | output | 1 | Oscillator select, 1 = transmit |
| test_qual | output | 1 | Test-mode qualifier |
| filt_en | output | 1 | Transmit filter enable |
| comp_en | output | 1 | Modulation compensation enable |
| dev_scale | output | 3 | Deviation scale code |
| pretune | output | 3 | Oscillator pretune code |
| cp_step | output | 3 | Charge-pump current step, signed |
| demod_tune | output | 5 | Demodulator tuning code |
| comp_scale | output | 3 | Compensation scale code |
| test_sel | output | 3 | Test-mode select |

## Verification
A serial clock rising edge and the return of enable can reach the controller in the same synchronized cycle. The bench provokes this by driving both lines high at the same instant on the final bit. It then judges that this bit was used as the address, by checking that the intended word received the expected fields and that the other word stayed unchanged. Zero-edge, over-long and short transfers, and clock toggling while enable is high, are each compared against an arithmetic model of the shift register.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
    localparam int SR_W   = 24;
    localparam int W1_W   = SR_W - 1;
    localparam int W2_W   = 11;
    localparam int BUS_W  = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } cfg_state_e;

    typedef struct packed {
        logic [1:0] ref_code;
        logic [4:0] swallow_cnt;
        logic [1:0] main_code;
        logic       osc_tx;
        logic       spare;
        logic       test_qual;
        logic       filt_en;
        logic       comp_en;
        logic [2:0] dev_scale;
        logic [2:0] pretune;
        logic [2:0] cp_step;
    } synth_word_t;

    typedef struct packed {
        logic [4:0] demod_tune;
        logic [2:0] comp_scale;
        logic [2:0] test_sel;
    } tune_word_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_shift_fsm.sv
module cfg_shift_fsm
    import serial_cfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_low,
    input  logic            clk_rise,
    input  logic            dat,
    output cfg_state_e      state,
    output logic            commit,
    output logic [SR_W-1:0] sreg
);
    cfg_state_e st_q, st_d;
    logic       got_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (en_low) st_d = ST_SHIFT;
            ST_SHIFT:  if (!en_low) st_d = (got_q || clk_rise) ? ST_COMMIT : ST_IDLE;
            ST_COMMIT: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // Datapath outputs: shift register and edge-seen flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg  <= '0;
            got_q <= 1'b0;
        end else begin
            if (st_q == ST_IDLE && en_low) begin
                sreg  <= '0;
                got_q <= 1'b0;
            end else if (st_q == ST_SHIFT && clk_rise) begin
                sreg  <= {sreg[SR_W-2:0], dat};
                got_q <= 1'b1;
            end
        end
    end

    assign state  = st_q;
    assign commit = (st_q == ST_COMMIT);
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import serial_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_en,
    output logic [1:0]        ref_code,
    output logic [4:0]        swallow_cnt,
    output logic [1:0]        main_code,
    output logic              osc_tx,
    output logic              test_qual,
    output logic              filt_en,
    output logic              comp_en,
    output logic [2:0]        dev_scale,
    output logic [2:0]        pretune,
    output logic signed [2:0] cp_step,
    output logic [4:0]        demod_tune,
    output logic [2:0]        comp_scale,
    output logic [2:0]        test_sel
);
    logic [BUS_W-1:0] bus_s;
    logic             sclk_prev_q;
    logic             clk_rise;
    logic             en_low;
    cfg_state_e       fsm_st;
    logic             commit;
    logic [SR_W-1:0]  sreg;
    logic             wr_synth, wr_tune;
    synth_word_t      synth_q;
    tune_word_t       tune_q;

    // bus_s = {enable, clock, data}; enable idles high
    cfg_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_en, ser_clk, ser_dat}),
        .q     (bus_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= bus_s[1];
    end

    assign clk_rise = bus_s[1] && !sclk_prev_q;
    assign en_low   = !bus_s[2];

    cfg_shift_fsm fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_low   (en_low),
        .clk_rise (clk_rise),
        .dat      (bus_s[0]),
        .state    (fsm_st),
        .commit   (commit),
        .sreg     (sreg)
    );

    assign wr_synth = commit && sreg[0];
    assign wr_tune  = commit && !sreg[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            synth_q <= '0;
            tune_q  <= '0;
        end else begin
            if (wr_synth) synth_q <= synth_word_t'(sreg[SR_W-1:1]);
            if (wr_tune)  tune_q  <= tune_word_t'(sreg[W2_W:1]);
        end
    end

    assign ref_code    = synth_q.ref_code;
    assign swallow_cnt = synth_q.swallow_cnt;
    assign main_code   = synth_q.main_code;
    assign osc_tx      = synth_q.osc_tx;
    assign test_qual   = synth_q.test_qual;
    assign filt_en     = synth_q.filt_en;
    assign comp_en     = synth_q.comp_en;
    assign dev_scale   = synth_q.dev_scale;
    assign pretune     = synth_q.pretune;
    assign cp_step     = $signed(synth_q.cp_step);
    assign demod_tune  = tune_q.demod_tune;
    assign comp_scale  = tune_q.comp_scale;
    assign test_sel    = tune_q.test_sel;
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk
    import serial_cfg_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input cfg_state_e      state,
    input logic            en_low,
    input logic            commit,
    input logic            wr_synth,
    input logic            wr_tune,
    input logic [SR_W-1:0] sreg,
    input logic [W1_W-1:0] synth_bits,
    input logic [W2_W-1:0] tune_bits
);
    assert_synth_on_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(synth_bits) |-> $past(wr_synth));

    assert_tune_on_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tune_bits) |-> $past(wr_tune));

    assert_commit_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    assert_idle_sreg_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !en_low) |=> $stable(sreg));

    assert_commit_sreg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> $stable(sreg));
endmodule

bind serial_cfg_port serial_cfg_port_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (fsm_st),
    .en_low     (en_low),
    .commit     (commit),
    .wr_synth   (wr_synth),
    .wr_tune    (wr_tune),
    .sreg       (sreg),
    .synth_bits (synth_q),
    .tune_bits  (tune_q)
);

// File: tb/serial_cfg_port_tb_top.sv
module serial_cfg_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b1;
    logic [1:0] ref_code, main_code;
    logic [4:0] swallow_cnt, demod_tune;
    logic osc_tx, test_qual, filt_en, comp_en;
    logic [2:0] dev_scale, pretune, comp_scale, test_sel;
    logic signed [2:0] cp_step;

    int n_chk = 0;
    int n_fail = 0;
    logic [22:0] exp_w1 = '0;
    logic [10:0] exp_w2 = '0;

    always #2 clk = ~clk;

    serial_cfg_port dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
        .ref_code(ref_code), .swallow_cnt(swallow_cnt), .main_code(main_code),
        .osc_tx(osc_tx), .test_qual(test_qual), .filt_en(filt_en), .comp_en(comp_en),
        .dev_scale(dev_scale), .pretune(pretune), .cp_step(cp_step),
        .demod_tune(demod_tune), .comp_scale(comp_scale), .test_sel(test_sel)
    );

    function automatic logic [22:0] got_w1();
        return {ref_code, swallow_cnt, main_code, osc_tx, 1'b0, test_qual,
                filt_en, comp_en, dev_scale, pretune, cp_step};
    endfunction

    task automatic check_all(input string tag);
        logic [22:0] e1;
        e1 = exp_w1 & ~(23'h1 << 12);
        n_chk++;
        if (got_w1() !== e1) begin
            n_fail++;
            $display("FAIL %s synth word: actual %h expected %h", tag, got_w1(), e1);
        end
        n_chk++;
        if ({demod_tune, comp_scale, test_sel} !== exp_w2) begin
            n_fail++;
            $display("FAIL %s tune word: actual %h expected %h", tag,
                     {demod_tune, comp_scale, test_sel}, exp_w2);
        end
    endtask

    // Drive one transfer of n bits (MSB first) and update the model.
    task automatic xfer(input logic [63:0] v, input int n, input bit simul, input bit mid);
        logic [23:0] sr;
        ser_en = 1'b0;
        #200;
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            #64;
            ser_clk = 1'b1;
            if (simul && i == 0) ser_en = 1'b1;
            #64;
            ser_clk = 1'b0;
        end
        if (mid && !simul) check_all("R10");
        #8;
        ser_en = 1'b1;
        sr = '0;
        for (int i = n - 1; i >= 0; i--) sr = {sr[22:0], v[i]};
        if (n > 0) begin
            if (sr[0]) exp_w1 = sr[23:1];
            else       exp_w2 = sr[11:1];
        end
        #248;
        ser_dat = 1'b0;
    endtask

    initial begin
        #(150000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #40;
        rst_n = 1'b1;
        #40;
        check_all("R1");

        // R2 / R4: synthesizer word patterns, tuning word must hold
        xfer({40'd0, 23'h5A5A5A, 1'b1}, 24, 1'b0, 1'b0); check_all("R2");
        xfer({40'd0, 23'h7FFFFF, 1'b1}, 24, 1'b0, 1'b0); check_all("R2");
        xfer({40'd0, 23'h012345, 1'b1}, 24, 1'b0, 1'b0); check_all("R4");
        xfer({40'd0, 23'h6C3A96, 1'b1}, 24, 1'b0, 1'b1); check_all("R2");

        // R3: sweep all demodulator codes, synthesizer word must hold
        for (int d = 0; d < 32; d++) begin
            logic [10:0] w;
            w = {d[4:0], d[2:0] ^ 3'b101, d[4:2]};
            xfer({40'd0, 12'hA5C ^ 12'(d), w, 1'b0}, 24, 1'b0, 1'b0);
            check_all("R3");
        end

        // R11: every charge-pump code read as a signed value
        for (int c = 0; c < 8; c++) begin
            int expc;
            expc = (c >= 4) ? c - 8 : c;
            xfer({40'd0, 20'h3B1C4, c[2:0], 1'b1}, 24, 1'b0, 1'b0);
            n_chk++;
            if (int'(cp_step) != expc) begin
                n_fail++;
                $display("FAIL R11 cp_step: actual %0d expected %0d", int'(cp_step), expc);
            end
        end

        // R5: 30-bit transfer, 6 leading bits dropped
        xfer({34'd0, 6'b111111, 23'h15AA55, 1'b1}, 30, 1'b0, 1'b0); check_all("R5");

        // R6: short transfer, upper positions zero
        xfer({55'd0, 8'b1011_0110, 1'b1}, 9, 1'b0, 1'b0); check_all("R6");
        xfer({58'd0, 5'b11011, 1'b0}, 6, 1'b0, 1'b0); check_all("R6");

        // R7: zero-edge transfer
        xfer(64'd0, 0, 1'b0, 1'b0); check_all("R7");

        // R8: clock toggles while enable high
        ser_dat = 1'b1;
        for (int k = 0; k < 10; k++) begin
            #64; ser_clk = 1'b1; #64; ser_clk = 1'b0;
        end
        #200;
        check_all("R8");
        xfer({61'd0, 3'b110}, 3, 1'b0, 1'b0); check_all("R8");

        // R9: last clock edge coincides with enable rise
        xfer({40'd0, 23'h2F0F0F, 1'b1}, 24, 1'b1, 1'b0); check_all("R9");
        xfer({40'd0, 12'hFFF, 11'h4D3, 1'b0}, 24, 1'b1, 1'b0); check_all("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule